// File: doc/BRIEF.md
# Read CAS Latency Pipeline

This block schedules the data return of an SDRAM-style read. A registered READ strobe enters a short start pipeline. The latency taken from the captured mode fields (two or three clocks) decides which stage launches the burst. The DQ output enable rises one clock before the first valid beat. A data-valid strobe with a beat index then runs for every beat of the programmed burst length. The enable falls in the clock after the last beat.

The mode fields are decoded inside the block: the CAS latency code, the operating-mode bits and the burst-length code. They are captured only while nothing is in flight. A reserved latency or burst code, or any operating mode other than normal, raises an error flag and causes READ strobes to be ignored. A READ that arrives during a burst starts a fresh countdown. The new burst's beats replace the old ones from its launch clock onward, so the enable stays high across the handover when the new data follows closely enough.

Top module: `read_cas_pipe`

## Requirements
- R1: After reset dq_oe, dq_valid and mode_err are low and dq_beat is zero.
- R2: With latency code 2 (mode_cl = 3'b010), a READ sampled at edge n drives dq_oe high from edge n+1 and dq_valid high from edge n+2.
- R3: With latency code 3 (mode_cl = 3'b011), a READ sampled at edge n drives dq_oe high from edge n+2 and dq_valid high from edge n+3.
- R4: dq_valid stays high for 2^mode_bl consecutive clocks (mode_bl 0..3 gives 1, 2, 4, 8 beats), and dq_beat counts 0, 1, 2, … across them.
- R5: dq_oe is high whenever dq_valid is high, and it falls in the same clock as dq_valid, after the last beat.
- R6: A latency code other than 2 or 3 sets mode_err, and a READ is then ignored (no dq_oe, no dq_valid).
- R7: An operating-mode field other than 2'b00 (normal) sets mode_err, and a READ is then ignored.
- R8: A burst-length code above 3 sets mode_err, and a READ is then ignored.
- R9: Mode inputs are captured only while no read is pending or bursting. Changes made mid-burst alter neither that burst's timing nor mode_err until the block is idle.
- R10: A READ accepted during a burst restarts the latency. Its beat 0 appears at edge k+latency, the old beats continue until then, and dq_oe stays high across the handover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_cmd | input | 1 | Registered READ command strobe |
| mode_cl | input | CL_W | CAS latency code (2 or 3 valid) |
| mode_op | input | OPM_W | Operating-mode field, 0 = normal |
| mode_bl | input | BL_W | Burst length code, beats = 2^code |
| dq_oe | output | 1 | DQ driver enable |
| dq_valid | output | 1 | Read data beat valid |
| dq_beat | output | MAX_BL_LOG2 | Index of the current beat |
| mode_err | output | 1 | Captured mode fields are reserved or non-normal |

## Verification
The bench builds the block with its default widths: a 3-bit latency code, a 2-bit operating field and a 3-bit burst code, with bursts up to eight beats. These widths reach both legal latencies, every legal burst length including the longest, and the reserved latency and burst codes 0, 1 and 4 to 7. An eight-beat burst is long enough for a second READ to land mid-burst and exercise the restart handover. A four-beat, latency-3 read is long enough to change every mode field while the read is in flight.

// File: rtl/read_cas_pipe.sv
module read_cas_pipe #(
  parameter int CL_W        = 3,
  parameter int OPM_W       = 2,
  parameter int BL_W        = 3,
  parameter int MAX_BL_LOG2 = 3
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_cmd,
  input  logic [CL_W-1:0]        mode_cl,
  input  logic [OPM_W-1:0]       mode_op,
  input  logic [BL_W-1:0]        mode_bl,
  output logic                   dq_oe,
  output logic                   dq_valid,
  output logic [MAX_BL_LOG2-1:0] dq_beat,
  output logic                   mode_err
);

  localparam logic [CL_W-1:0] CL_TWO   = CL_W'(2);
  localparam logic [CL_W-1:0] CL_THREE = CL_W'(3);
  localparam logic [BL_W-1:0] BL_MAX   = BL_W'(MAX_BL_LOG2);

  logic [CL_W-1:0]        cfg_cl;
  logic [OPM_W-1:0]       cfg_op;
  logic [BL_W-1:0]        cfg_bl;
  logic [2:0]             pipe;
  logic [MAX_BL_LOG2-1:0] rem;
  logic [MAX_BL_LOG2-1:0] bl_last;
  logic                   idle, cl3, accept, oe_pre, launch;

  function automatic logic mode_ok(input logic [CL_W-1:0] cl,
                                   input logic [OPM_W-1:0] op,
                                   input logic [BL_W-1:0] bl);
    return (cl == CL_TWO || cl == CL_THREE) && (op == '0) && (bl <= BL_MAX);
  endfunction

  assign idle     = (pipe == '0) && (rem == '0);
  assign accept   = rd_cmd && (idle ? mode_ok(mode_cl, mode_op, mode_bl)
                                    : mode_ok(cfg_cl, cfg_op, cfg_bl));
  assign cl3      = (cfg_cl == CL_THREE);
  assign oe_pre   = cl3 ? pipe[1] : pipe[0];
  assign launch   = cl3 ? pipe[2] : pipe[1];
  assign bl_last  = MAX_BL_LOG2'((32'd1 << cfg_bl) - 32'd1);
  assign mode_err = !mode_ok(cfg_cl, cfg_op, cfg_bl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_cl   <= CL_TWO;
      cfg_op   <= '0;
      cfg_bl   <= '0;
      pipe     <= '0;
      rem      <= '0;
      dq_valid <= 1'b0;
      dq_oe    <= 1'b0;
      dq_beat  <= '0;
    end else begin
      if (idle) begin
        cfg_cl <= mode_cl;
        cfg_op <= mode_op;
        cfg_bl <= mode_bl;
      end
      pipe  <= {pipe[1] & cl3, pipe[0], accept};
      dq_oe <= oe_pre | launch | (rem != '0);
      if (launch) begin
        rem      <= bl_last;
        dq_valid <= 1'b1;
        dq_beat  <= '0;
      end else if (rem != '0) begin
        rem      <= rem - 1'b1;
        dq_valid <= 1'b1;
        dq_beat  <= dq_beat + 1'b1;
      end else begin
        dq_valid <= 1'b0;
        dq_beat  <= '0;
      end
    end
  end

endmodule

module read_cas_pipe_chk #(
  parameter int MAX_BL_LOG2 = 3
)(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   dq_oe,
  input logic                   dq_valid,
  input logic [MAX_BL_LOG2-1:0] dq_beat,
  input logic                   mode_err,
  input logic                   busy
);

  a_r5_valid_has_oe: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid |-> dq_oe);

  a_r2_oe_leads_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_valid) |-> $past(dq_oe));

  a_r5_oe_falls_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> ($past(dq_valid) && !dq_valid));

  a_r4_beat_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_valid && $past(dq_valid) && dq_beat != '0) |-> (dq_beat == $past(dq_beat) + 1'b1));

  a_r6_err_silences_dq: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> !dq_oe);

  a_r9_err_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_err));

endmodule

bind read_cas_pipe read_cas_pipe_chk #(.MAX_BL_LOG2(MAX_BL_LOG2)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dq_oe    (dq_oe),
  .dq_valid (dq_valid),
  .dq_beat  (dq_beat),
  .mode_err (mode_err),
  .busy     (!idle)
);

// File: tb/sim_read_cas_pipe.sv
`timescale 1ns/1ps
module sim_read_cas_pipe;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_cmd = 1'b0;
  logic [2:0] mode_cl = 3'd2;
  logic [1:0] mode_op = 2'd0;
  logic [2:0] mode_bl = 3'd0;
  logic       dq_oe, dq_valid, mode_err;
  logic [2:0] dq_beat;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  read_cas_pipe u0 (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd),
    .mode_cl(mode_cl), .mode_op(mode_op), .mode_bl(mode_bl),
    .dq_oe(dq_oe), .dq_valid(dq_valid), .dq_beat(dq_beat), .mode_err(mode_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_mode(input logic [2:0] cl, input logic [1:0] op, input logic [2:0] bl);
    @(negedge clk);
    mode_cl = cl; mode_op = op; mode_bl = bl;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "dq_oe", dq_oe, 0);
    chk("R1", "dq_valid", dq_valid, 0);
    chk("R1", "mode_err", mode_err, 0);
    chk("R1", "dq_beat", dq_beat, 0);
  endtask

  task automatic run_burst(input string tag, input logic [2:0] cl,
                           input logic [1:0] op, input logic [2:0] bl);
    bit ok;
    int m, nb;
    ok = (cl == 3'd2 || cl == 3'd3) && op == 2'd0 && bl <= 3'd3;
    m  = (cl == 3'd3) ? 3 : 2;
    nb = 1 << bl;
    set_mode(cl, op, bl);
    chk(tag, "mode_err", mode_err, ok ? 0 : 1);
    rd_cmd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_cmd = 1'b0;
    for (int j = 0; j < 16; j++) begin
      bit eo, ev;
      eo = ok && j >= m - 1 && j <= m + nb - 1;
      ev = ok && j >= m && j <= m + nb - 1;
      chk(tag, $sformatf("dq_oe j=%0d", j), dq_oe, eo);
      chk(tag, $sformatf("dq_valid j=%0d", j), dq_valid, ev);
      if (ev) chk(tag, $sformatf("dq_beat j=%0d", j), dq_beat, j - m);
      @(negedge clk);
    end
  endtask

  task automatic test_busy_mode();
    set_mode(3'd3, 2'd0, 3'd2);
    rd_cmd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_cmd = 1'b0;
    for (int j = 0; j < 12; j++) begin
      chk("R9", $sformatf("dq_oe j=%0d", j), dq_oe, (j >= 2 && j <= 6));
      chk("R9", $sformatf("dq_valid j=%0d", j), dq_valid, (j >= 3 && j <= 6));
      if (j >= 3 && j <= 6) chk("R9", $sformatf("dq_beat j=%0d", j), dq_beat, j - 3);
      chk("R9", $sformatf("mode_err j=%0d", j), mode_err, (j >= 7));
      if (j == 1) begin
        mode_cl = 3'd2; mode_op = 2'd1; mode_bl = 3'd0;
      end
      @(negedge clk);
    end
    set_mode(3'd2, 2'd0, 3'd0);
    chk("R9", "mode_err cleared", mode_err, 0);
  endtask

  task automatic test_restart();
    set_mode(3'd2, 2'd0, 3'd3);
    rd_cmd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_cmd = 1'b0;
    for (int j = 0; j < 16; j++) begin
      bit ev;
      ev = (j >= 2 && j <= 12);
      chk("R10", $sformatf("dq_oe j=%0d", j), dq_oe, (j >= 1 && j <= 12));
      chk("R10", $sformatf("dq_valid j=%0d", j), dq_valid, ev);
      if (ev) chk("R10", $sformatf("dq_beat j=%0d", j), dq_beat, (j <= 4) ? j - 2 : j - 5);
      if (j == 2) rd_cmd = 1'b1;
      if (j == 3) rd_cmd = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    run_burst("R2", 3'd2, 2'd0, 3'd2);
    run_burst("R3", 3'd3, 2'd0, 3'd1);
    run_burst("R4", 3'd2, 2'd0, 3'd0);
    run_burst("R4", 3'd3, 2'd0, 3'd3);
    run_burst("R5", 3'd2, 2'd0, 3'd1);
    run_burst("R6", 3'd1, 2'd0, 3'd1);
    run_burst("R6", 3'd4, 2'd0, 3'd1);
    run_burst("R7", 3'd2, 2'd2, 3'd1);
    run_burst("R7", 3'd3, 2'd1, 3'd2);
    run_burst("R8", 3'd2, 2'd0, 3'd4);
    run_burst("R8", 3'd3, 2'd0, 3'd7);
    run_burst("R2", 3'd2, 2'd0, 3'd3);
    test_busy_mode();
    test_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule